// File: doc/BRIEF.md
# Dynamic Bus-Size Acknowledge Generator

This block is the slave-side handshake of a peripheral whose data always occupies the upper lanes of a 32-bit asynchronous bus. A cycle begins when the synchronized address strobe falls. The block then reports "wait" (both acknowledge lines high) on two active-low lines until the register file raises its ready signal. After that it presents a two-bit code that tells the bus master how wide the returned data is and which lanes carry it. The code is chosen from the configured port width and address bit A4. On a 32-bit port a 16-bit register is reported as word-wide, because the data is never moved to the lower half.

When the address strobe or the data strobe is negated, the block drives both lines high for exactly one clock to speed up their rise time. It then releases its output enable so the lines float before the next cycle. A strobe negation before ready arrives aborts the cycle. In that case no width code is ever shown.

The block also qualifies the external reset pin. A low pulse shorter than three clocks is ignored. A longer one raises a register-initialisation request for the register file, which clears the control, status and instruction-address registers and fills every data register with a quiet-NaN pattern. While that request is high, the handshake is held idle.

Top module: `bus_width_ack`

## Requirements
- R1: With portWidth = 2'b00 (32-bit) and addrA4 = 1, the acknowledge code is ackOut = 2'b00 (bit 1 is acknowledge-1, bit 0 is acknowledge-0; both low means 32 valid lanes).
- R2: With portWidth = 2'b00 and addrA4 = 0, the code is ackOut = 2'b01 (acknowledge-1 low, acknowledge-0 high: 16-bit data on the upper lanes).
- R3: With portWidth = 2'b01 (16-bit), the code is ackOut = 2'b01 for either value of addrA4.
- R4: With portWidth = 2'b10 or 2'b11 (8-bit), the code is ackOut = 2'b10.
- R5: Once a cycle has started and dataReady is low, ackOe = 1 and ackOut = 2'b11 (wait state).
- R6: The width code appears at the first clock edge that samples dataReady high, and it is held unchanged until the strobes end the cycle.
- R7: After the synchronized address strobe goes high or the data strobe rises, ackOe stays 1 with ackOut = 2'b11 for exactly one clock, and then ackOe drops to 0.
- R8: If the strobes end the cycle before dataReady is seen, no width code is ever driven. The block goes through the one-clock pull-up and then releases.
- R9: An extRstN low pulse lasting fewer than 3 clocks never raises regInit.
- R10: An extRstN low lasting 3 or more clocks raises regInit until the pin returns high. While regInit is high, a falling address strobe does not start a cycle (ackOe stays 0).
- R11: After rstN, ackOe = 0 and regInit = 0.
- R12: A cycle starts only on a high-to-low change of the synchronized address strobe. An address strobe that stays low after a cycle ended by the data strobe does not start another cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Chip-level asynchronous reset, active low |
| extRstN | input | 1 | External reset pin, asynchronous, active low, qualified by length |
| asN | input | 1 | Address strobe, asynchronous, active low |
| dsN | input | 1 | Data strobe, asynchronous, active low |
| portWidth | input | 2 | Configured port width: 00 = 32, 01 = 16, 10/11 = 8 |
| addrA4 | input | 1 | Address bit A4 of the access |
| dataReady | input | 1 | Register file has the data ready |
| ackOut | output | 2 | Acknowledge line values {ack1, ack0}, active low |
| ackOe | output | 1 | Output enable of both acknowledge line drivers |
| regInit | output | 1 | Qualified reset: initialise the register file |

## Verification
The hardest situations to reach are the ones where strobe timing races the ready signal. One is a cycle aborted before ready, where the bench must show that no width code appeared on any clock. The other is the data strobe ending a cycle while the address strobe stays low, which must not start a second cycle. Directed tasks reach these by negating the strobes at chosen clocks, with dataReady either held low or raised first. Every clock from the negation to the release is sampled, so the lone pull-up clock and the release after it are both observed. Reset qualification is exercised with pulses just below and at the three-clock threshold. A bus cycle is also started while the request is high, to confirm it is blocked.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int ACK_LINES = 2;
  typedef logic [ACK_LINES-1:0] ack_code_t;

  localparam ack_code_t CODE_WAIT = 2'b11;
  localparam ack_code_t CODE_LONG = 2'b00;
  localparam ack_code_t CODE_WORD = 2'b01;
  localparam ack_code_t CODE_BYTE = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_PULL} ack_state_e;

  typedef struct packed {
    logic capture;   // latch the width code for a new cycle
    logic drive;     // acknowledge drivers enabled
    logic showCode;  // present the latched width code
  } ack_ctl_t;

  // Width code from port configuration; narrow registers always use upper lanes.
  function automatic ack_code_t width_code(input logic [1:0] portWidth, input logic addrA4);
    case (portWidth)
      2'b00:   return addrA4 ? CODE_LONG : CODE_WORD;
      2'b01:   return CODE_WORD;
      default: return CODE_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/bwa_sync.sv
module bwa_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '1;
    else       stageQ <= {stageQ[STAGES-2:0], din};
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
#(
  parameter int MIN_RST_CLKS = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     asS,
  input  logic     dsS,
  input  logic     extRstS,
  input  logic     dataReady,
  output ack_ctl_t ctl,
  output logic     regInit
);
  localparam int CNT_W = $clog2(MIN_RST_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RST_CLKS);

  ack_state_e state, nextState;
  logic asPrev, dsPrev;
  logic asFall, dsRise, endCond;
  logic [CNT_W-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev <= 1'b1;
      dsPrev <= 1'b1;
    end else begin
      asPrev <= asS;
      dsPrev <= dsS;
    end
  end

  assign asFall  = asPrev & ~asS;
  assign dsRise  = ~dsPrev & dsS;
  assign endCond = asS | dsRise;

  // Reset qualifier: count consecutive low samples of the synchronized pin.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rstCnt <= '0;
    else if (extRstS)         rstCnt <= '0;
    else if (rstCnt != CNT_MAX) rstCnt <= rstCnt + 1'b1;
  end

  assign regInit = (rstCnt == CNT_MAX);

  always_comb begin
    nextState = state;
    if (regInit) nextState = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (asFall) nextState = ST_WAIT;
        ST_WAIT: begin
          if (endCond)        nextState = ST_PULL;
          else if (dataReady) nextState = ST_ACK;
        end
        ST_ACK:  if (endCond) nextState = ST_PULL;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl.capture  = (state == ST_IDLE) && asFall && !regInit;
    ctl.drive    = (state != ST_IDLE);
    ctl.showCode = (state == ST_ACK);
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !dataReady && !endCond && !regInit) |=> state == ST_WAIT); // R5
  AST_ABORT_TO_PULL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && endCond && !regInit) |=> state == ST_PULL); // R8
  AST_PULL_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PULL |=> state == ST_IDLE); // R7
  AST_INIT_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    regInit |-> !$past(extRstS)); // R9
  AST_INIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    regInit |=> state == ST_IDLE); // R10
endmodule

// File: rtl/bwa_dp.sv
module bwa_dp
  import bwa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ack_ctl_t             ctl,
  input  logic [1:0]           portWidth,
  input  logic                 addrA4,
  output logic [ACK_LINES-1:0] ackOut,
  output logic                 ackOe
);
  ack_code_t codeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            codeQ <= CODE_WAIT;
    else if (ctl.capture) codeQ <= width_code(portWidth, addrA4);
  end

  // Each line: latched code bit while acknowledging, negated level otherwise.
  for (genvar g = 0; g < ACK_LINES; g++) begin : gLine
    assign ackOut[g] = ctl.showCode ? codeQ[g] : 1'b1;
  end

  assign ackOe = ctl.drive;

  AST_RELEASE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOe) |-> $past(ackOut) == CODE_WAIT); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.showCode && $past(ctl.showCode)) |-> $stable(ackOut)); // R6
endmodule

// File: rtl/bus_width_ack.sv
module bus_width_ack
  import bwa_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_RST_CLKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extRstN,
  input  logic       asN,
  input  logic       dsN,
  input  logic [1:0] portWidth,
  input  logic       addrA4,
  input  logic       dataReady,
  output logic [1:0] ackOut,
  output logic       ackOe,
  output logic       regInit
);
  logic [2:0] syncOut;
  ack_ctl_t   ctl;

  bwa_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din({extRstN, dsN, asN}), .dout(syncOut)
  );

  bwa_ctrl #(.MIN_RST_CLKS(MIN_RST_CLKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .asS(syncOut[0]), .dsS(syncOut[1]),
    .extRstS(syncOut[2]), .dataReady(dataReady), .ctl(ctl), .regInit(regInit)
  );

  bwa_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portWidth(portWidth),
    .addrA4(addrA4), .ackOut(ackOut), .ackOe(ackOe)
  );
endmodule

// File: tb/bus_width_ack_tb_top.sv
module bus_width_ack_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN, extRstN, asN, dsN, addrA4, dataReady;
  logic [1:0] portWidth, ackOut;
  logic ackOe, regInit;
  int compared = 0;
  int mismatched = 0;
  bit initSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (regInit === 1'b1) initSeen = 1'b1;

  bus_width_ack dut_i (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .asN(asN), .dsN(dsN),
    .portWidth(portWidth), .addrA4(addrA4), .dataReady(dataReady),
    .ackOut(ackOut), .ackOe(ackOe), .regInit(regInit)
  );

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full cycle: wait state, code, end by AS (or DS only), pull-up, release.
  task automatic runCycle(input logic [1:0] w, input logic a4, input logic [1:0] expCode,
                          input bit dsOnly, input string req);
    int phase;
    bit badSeq, pullOk, relOk;
    @(negedge clk);
    portWidth = w; addrA4 = a4; dataReady = 1'b0; asN = 1'b0; dsN = 1'b0;
    waitNeg(5);
    check(ackOe === 1'b1 && ackOut === 2'b11, "R5 wait", {1'b0, ackOe, ackOut}, 4'h7);
    dataReady = 1'b1;
    @(posedge clk); @(negedge clk);
    check(ackOe === 1'b1 && ackOut === expCode, req, {2'b0, ackOut}, {2'b0, expCode});
    waitNeg(2);
    check(ackOut === expCode, "R6 code held", {2'b0, ackOut}, {2'b0, expCode});
    dataReady = 1'b0;
    dsN = 1'b1;
    if (!dsOnly) asN = 1'b1;
    phase = 0; badSeq = 0; pullOk = 0; relOk = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (phase == 0) begin
        if (ackOe === 1'b1 && ackOut === expCode) ;
        else if (ackOe === 1'b1 && ackOut === 2'b11) begin pullOk = 1; phase = 1; end
        else badSeq = 1;
      end else begin
        relOk = (ackOe === 1'b0);
        break;
      end
    end
    check(pullOk && !badSeq, "R7 pull-up phase", {2'b0, pullOk, badSeq}, 4'h2);
    check(relOk, "R7 release after one clock", {3'b0, relOk}, 4'h1);
    if (dsOnly) begin
      waitNeg(6);
      check(ackOe === 1'b0, "R12 no restart while AS low", {3'b0, ackOe}, 4'h0);
      asN = 1'b1;
      waitNeg(4);
    end
  endtask

  task automatic abortCycle();
    bit codeSeen = 0;
    bit driven = 0;
    @(negedge clk);
    portWidth = 2'b00; addrA4 = 1'b1; dataReady = 1'b0; asN = 1'b0; dsN = 1'b0;
    waitNeg(5);
    asN = 1'b1; dsN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ackOe === 1'b1) driven = 1;
      if (ackOe === 1'b1 && ackOut !== 2'b11) codeSeen = 1;
    end
    check(!codeSeen && driven, "R8 abort shows no code", {2'b0, codeSeen, driven}, 4'h1);
    check(ackOe === 1'b0, "R8 released after abort", {3'b0, ackOe}, 4'h0);
    // ready arriving after the abort must not revive the cycle
    dataReady = 1'b1;
    waitNeg(3);
    check(ackOe === 1'b0, "R8 late ready ignored", {3'b0, ackOe}, 4'h0);
    dataReady = 1'b0;
  endtask

  task automatic shortReset();
    @(negedge clk);
    initSeen = 0;
    extRstN = 1'b0;
    waitNeg(2);
    extRstN = 1'b1;
    waitNeg(8);
    check(!initSeen, "R9 short reset ignored", {3'b0, initSeen}, 4'h0);
  endtask

  task automatic longReset();
    @(negedge clk);
    extRstN = 1'b0;
    waitNeg(6);
    check(regInit === 1'b1, "R10 qualified reset", {3'b0, regInit}, 4'h1);
    asN = 1'b0; dsN = 1'b0;
    waitNeg(5);
    check(ackOe === 1'b0, "R10 bus held idle", {3'b0, ackOe}, 4'h0);
    extRstN = 1'b1;
    waitNeg(6);
    check(regInit === 1'b0, "R10 request drops", {3'b0, regInit}, 4'h0);
    check(ackOe === 1'b0, "R12 no cycle without AS fall", {3'b0, ackOe}, 4'h0);
    asN = 1'b1; dsN = 1'b1;
    waitNeg(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; extRstN = 1'b1; asN = 1'b1; dsN = 1'b1;
    portWidth = 2'b00; addrA4 = 1'b0; dataReady = 1'b0;
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(2);
    check(ackOe === 1'b0 && regInit === 1'b0, "R11 reset state", {2'b0, ackOe, regInit}, 4'h0);

    runCycle(2'b00, 1'b1, 2'b00, 1'b0, "R1 32-bit A4=1");
    runCycle(2'b00, 1'b0, 2'b01, 1'b0, "R2 32-bit A4=0");
    runCycle(2'b01, 1'b0, 2'b01, 1'b0, "R3 16-bit A4=0");
    runCycle(2'b01, 1'b1, 2'b01, 1'b1, "R3 16-bit A4=1 DS end");
    runCycle(2'b10, 1'b0, 2'b10, 1'b0, "R4 8-bit");
    runCycle(2'b11, 1'b1, 2'b10, 1'b1, "R4 8-bit alt DS end");
    abortCycle();
    shortReset();
    longReset();
    runCycle(2'b00, 1'b1, 2'b00, 1'b0, "R6 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule